// File: doc/BRIEF.md
# 16-bit Timer with Compare-Reset Trigger

This block is a 16-bit up-counter built from two byte registers. It advances either on a single-cycle internal tick or on rising edges of an external clock input. The external input can be resynchronised through a two-stage flip-flop chain or taken directly for free-running operation. Each rollover from all ones to zero sets a sticky overflow flag. An interrupt request is raised when the flag and three enable levels (local, peripheral, global) are all high.

A compare-match pulse from a neighbouring compare engine clears the counter, so the compare value sets the period. A bus write port loads either counter byte or the flag, and a combinational read port returns a byte chosen by address. In low-power mode only free-running external counting continues. An overflow there raises a wake output, which needs only the local and peripheral enables.

The compare engine, comparator and processor are outside the block. Their effects arrive as plain input pulses and levels.

Top module: `timer16_cmp`

## Requirements
- R1: While the timer is on and a count event occurs, the 16-bit count increases by one, and 0xFFFF is followed by 0x0000. In internal mode a count event is `tick_en` high at a clock edge.
- R2: A rollover sets the overflow flag, and the flag stays set until a bus write to address 2 with data bit 0 clear. A rollover in the same cycle as that write leaves the flag set. A write to address 2 with bit 0 set also sets the flag.
- R3: `irq` is high exactly when the flag, `ie_local`, `ie_periph` and `ie_global` are all high.
- R4: A `trig_pulse` clears both bytes to zero and never sets the flag, even when a rollover would have happened in that cycle. When external free-running counting is selected (`src_ext`=1, `ext_async`=1), the pulse is ignored.
- R5: A bus write to address 0 loads the low byte and a write to address 1 loads the high byte, leaving the other byte unchanged. A write that coincides with a trigger wins over the clear.
- R6: In external mode (`src_ext`=1), rising edges are counted only after a falling edge on the external input has been seen since the timer was turned on with external mode selected. Until then the count holds.
- R7: With `ext_async`=0, a rising edge applied to `ext_clk_in` shows up in the count after the third clock edge. With `ext_async`=1, it shows up after the next clock edge.
- R8: With `low_power`=1, the count holds unless `src_ext`=1, `ext_async`=1 and `tmr_on`=1. `wake` is high when `low_power`, the flag, `ie_local` and `ie_periph` are all high, regardless of `ie_global`.
- R9: With `tmr_on`=0 the count holds, but bus writes still load the counter bytes.
- R10: `rd_data` shows the low byte at `rd_addr`=0 and the high byte at 1. At 2 it shows the flag in bit 0 with zeros above it, and at 3 it shows zero. Reset clears the count and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Internal count enable, one pulse per count |
| ext_clk_in | input | 1 | External count input |
| tmr_on | input | 1 | Gates all counting |
| src_ext | input | 1 | 1 selects the external input as count source |
| ext_async | input | 1 | 1 bypasses the synchroniser (free-running) |
| low_power | input | 1 | System is in low-power state |
| trig_pulse | input | 1 | Compare-match clear pulse |
| ie_local | input | 1 | Timer interrupt enable |
| ie_periph | input | 1 | Peripheral interrupt enable |
| ie_global | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 low byte, 1 high byte, 2 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request in low-power mode |

## Verification
The embedded assertions check the following on every cycle:
- an increment steps the count by one, and a rollover lands on zero and raises the flag;
- the flag holds without a clearing write;
- a trigger never raises the flag, and a write beats a simultaneous trigger;
- an unarmed external source and a disallowed low-power state both freeze the count;
- a free-running source ignores the trigger.

The enable-chain truth table, the two external-edge latencies and the arming sequence depend on how the stimulus is ordered, so only the bench scenarios can show them. The same applies to wake without the global enable and to the read-address map. The bench compares every cycle against its behavioural model while those scenarios run.

// File: rtl/timer16_pkg.sv
// Shared types for the 16-bit timer.
// Assumes: mode bits are static levels sampled each clock.
package timer16_pkg;

    // Operating mode of the timer as one bundle
    typedef struct packed {
        logic on;
        logic ext;
        logic async_sel;
        logic low_pwr;
    } t16_mode_t;

    // True when the external source runs without the synchroniser
    function automatic logic t16_free_running(input t16_mode_t m);
        return m.ext && m.async_sel;
    endfunction

    // True when the counter may advance in the present power state
    function automatic logic t16_may_run(input t16_mode_t m);
        return m.on && (!m.low_pwr || t16_free_running(m));
    endfunction

endpackage

// File: rtl/t16_edge_sync.sv
// External count-edge detector.
// Resynchronises the external input through SYNC_STAGES flops unless
// use_async is set. It detects rising and falling edges of the chosen
// source and arms counting only after a falling edge seen while enabled.
// Assumes: ext_in is a slow level; in async mode it is stable around clk edges.
module t16_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic use_async,
    input  logic ext_enabled,
    output logic count_edge,
    output logic armed
);

    logic synced;
    logic sel_lvl;
    logic prev_q;
    logic rise;
    logic fall;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic s_q;
            // Single-stage capture of the external input
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= ext_in;
            end
            assign synced = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            // Multi-stage shift chain for metastability settling
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC_STAGES-2:0], ext_in};
            end
            assign synced = s_q[SYNC_STAGES-1];
        end
    endgenerate

    assign sel_lvl = use_async ? ext_in : synced;
    assign rise    = sel_lvl && !prev_q;
    assign fall    = !sel_lvl && prev_q;

    // Remember last level of the selected source for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_lvl;
    end

    // Arm on the first falling edge while enabled; disarm when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)           armed <= 1'b0;
        else if (!ext_enabled) armed <= 1'b0;
        else if (fall)        armed <= 1'b1;
    end

    assign count_edge = rise && armed && ext_enabled;

endmodule

// File: rtl/t16_counter.sv
// Byte-sliced up-counter with write and clear priority.
// Priority per cycle: byte write, then clear, then increment.
// A write to one byte freezes the other byte for that cycle.
// wrap pulses when an increment actually carries out of the top byte.
// Assumes: clr is already qualified by the caller's mode rules.
module t16_counter #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 2,
    parameter int ADDR_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [BYTE_W*N_BYTES-1:0]   count,
    output logic                        wrap
);

    localparam int CNT_W = BYTE_W * N_BYTES;

    logic [N_BYTES:0]   carry;
    logic [N_BYTES-1:0] byte_we;
    logic               any_we;

    assign carry[0] = inc;
    assign any_we   = |byte_we;

    generate
        for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
            logic [BYTE_W-1:0] byte_q;

            assign byte_we[i]   = wr_en && (wr_addr == ADDR_W'(i));
            assign carry[i+1]   = carry[i] && (&byte_q);
            assign count[i*BYTE_W +: BYTE_W] = byte_q;

            // One counter byte: write beats clear, clear beats increment
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (any_we) begin
                    if (byte_we[i]) byte_q <= wr_data;
                end else if (clr) begin
                    byte_q <= '0;
                end else if (carry[i]) begin
                    byte_q <= byte_q + 1'b1;
                end
            end
        end
    endgenerate

    assign wrap = carry[N_BYTES] && !any_we && !clr;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !any_we && !clr) |=> (count == $past(count) + CNT_W'(1))); // R1
    AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0)); // R1
    AST_WRITE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && byte_we[0]) |=> (count[BYTE_W-1:0] == $past(wr_data))); // R5

endmodule

// File: rtl/t16_irq.sv
// Overflow flag and request logic.
// Holds the sticky overflow flag. A rollover sets it and wins over a
// same-cycle software write. Drives irq through the three-level enable
// chain and wake through the local and peripheral enables in low power.
// Assumes: flag_wr is a single-cycle bus write strobe.
module t16_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic ie_local,
    input  logic ie_periph,
    input  logic ie_global,
    input  logic low_power,
    output logic flag,
    output logic irq,
    output logic wake
);

    logic chain_lp;

    // Sticky overflow flag: set by rollover, else written by software
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (wrap)    flag <= 1'b1;
        else if (flag_wr) flag <= flag_wdata;
    end

    assign chain_lp = flag && ie_local && ie_periph;
    assign irq      = chain_lp && ie_global;
    assign wake     = chain_lp && low_power;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_wr) |=> flag); // R2
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag); // R2

endmodule

// File: rtl/timer16_cmp.sv
// 16-bit timer with compare-reset trigger (top).
// Selects the count source, applies the power and on/off gating,
// qualifies the compare trigger, and muxes the byte read port.
// Address map: bytes at 0..N_BYTES-1 (low first), flag at N_BYTES, rest read 0.
// Assumes: all inputs are synchronous to clk except ext_clk_in.
module timer16_cmp #(
    parameter int BYTE_W      = 8,
    parameter int N_BYTES     = 2,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ext_clk_in,
    input  logic              tmr_on,
    input  logic              src_ext,
    input  logic              ext_async,
    input  logic              low_power,
    input  logic              trig_pulse,
    input  logic              ie_local,
    input  logic              ie_periph,
    input  logic              ie_global,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              wake
);

    import timer16_pkg::*;

    localparam int                CNT_W     = BYTE_W * N_BYTES;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_BYTES);

    t16_mode_t        mode;
    logic             count_edge;
    logic             armed;
    logic             inc;
    logic             trig_eff;
    logic             wrap;
    logic             flag;
    logic             flag_wr;
    logic [CNT_W-1:0] count;

    assign mode = '{on: tmr_on, ext: src_ext, async_sel: ext_async, low_pwr: low_power};

    t16_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_in      (ext_clk_in),
        .use_async   (ext_async),
        .ext_enabled (tmr_on && src_ext),
        .count_edge  (count_edge),
        .armed       (armed)
    );

    // Count event: power/on gating, then source choice
    always_comb begin
        inc = 1'b0;
        if (t16_may_run(mode))
            inc = src_ext ? count_edge : tick_en;
    end

    // Trigger acts only when the count path is synchronous
    assign trig_eff = trig_pulse && !t16_free_running(mode);
    assign flag_wr  = wr_en && (wr_addr == STAT_ADDR);

    t16_counter #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .ADDR_W(ADDR_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .clr     (trig_eff),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count   (count),
        .wrap    (wrap)
    );

    t16_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .flag_wr    (flag_wr),
        .flag_wdata (wr_data[0]),
        .ie_local   (ie_local),
        .ie_periph  (ie_periph),
        .ie_global  (ie_global),
        .low_power  (low_power),
        .flag       (flag),
        .irq        (irq),
        .wake       (wake)
    );

    // Byte read mux: counter bytes, then flag, then zero
    always_comb begin
        rd_data = '0;
        if (rd_addr < STAT_ADDR)
            rd_data = count[rd_addr*BYTE_W +: BYTE_W];
        else if (rd_addr == STAT_ADDR)
            rd_data = {{(BYTE_W-1){1'b0}}, flag};
    end

    AST_TRIG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_eff && !flag_wr && !flag) |=> !flag); // R4
    AST_ASYNC_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && src_ext && ext_async && !wr_en && !inc) |=> (count == $past(count))); // R4
    AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && !armed && !wr_en && !trig_eff) |=> (count == $past(count))); // R6
    AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !(src_ext && ext_async) && !wr_en && !trig_eff) |=> (count == $past(count))); // R8
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_on && !wr_en && !trig_eff) |=> (count == $past(count))); // R9

endmodule

// File: tb/timer16_cmp_tb.sv
// Bench for timer16_cmp.
// A behavioural model is updated at each rising edge and compared every cycle.
// Directed scenarios add explicit checks per requirement.
module timer16_cmp_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 0, ext_clk_in = 0, tmr_on = 0, src_ext = 0, ext_async = 0;
    logic       low_power = 0, trig_pulse = 0, ie_local = 0, ie_periph = 0, ie_global = 0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    timer16_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk_in(ext_clk_in),
        .tmr_on(tmr_on), .src_ext(src_ext), .ext_async(ext_async), .low_power(low_power),
        .trig_pulse(trig_pulse), .ie_local(ie_local), .ie_periph(ie_periph),
        .ie_global(ie_global), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_cnt = 0;
    bit m_flag = 0, m_arm = 0, m_prev = 0;
    bit hist[$];

    always @(posedge clk) begin
        bit syncv, selv, rise, fall, ext_on, run, do_inc, trg, wrp;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_arm = 0; m_prev = 0;
            hist.delete();
        end else begin
            syncv  = (hist.size() >= 2) ? hist[hist.size()-2] : 1'b0;
            selv   = ext_async ? ext_clk_in : syncv;
            rise   = selv && !m_prev;
            fall   = !selv && m_prev;
            ext_on = tmr_on && src_ext;
            run    = !low_power || (src_ext && ext_async);
            do_inc = tmr_on && run && (src_ext ? (rise && m_arm) : tick_en);
            trg    = trig_pulse && !(src_ext && ext_async);
            wrp    = 0;
            if (wr_en && wr_addr == 2'd0)      m_cnt = (m_cnt & 32'hFF00) | int'(wr_data);
            else if (wr_en && wr_addr == 2'd1) m_cnt = (m_cnt & 32'h00FF) | (int'(wr_data) << 8);
            else if (trg)                      m_cnt = 0;
            else if (do_inc) begin
                wrp   = (m_cnt == 65535);
                m_cnt = (m_cnt + 1) % 65536;
            end
            if (wrp) m_flag = 1;
            else if (wr_en && wr_addr == 2'd2) m_flag = wr_data[0];
            if (!ext_on)   m_arm = 0;
            else if (fall) m_arm = 1;
            m_prev = selv;
            hist.push_back(ext_clk_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt & 255;
            2'd1: return (m_cnt >> 8) & 255;
            2'd2: return int'(m_flag);
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison, mid-way between drive and next rising edge
    always begin
        @(negedge clk);
        #5;
        if (cmp_on) begin
            check("R10 per-cycle rd_data", int'(rd_data), exp_rd(rd_addr));
            check("R3 per-cycle irq", int'(irq), int'(m_flag && ie_local && ie_periph && ie_global));
            check("R8 per-cycle wake", int'(wake), int'(m_flag && ie_local && ie_periph && low_power));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic chk_count(input string tag, input int exp);
        int lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        check(tag, (hi << 8) | lo, exp);
    endtask

    task automatic chk_flag(input string tag, input int exp);
        int f;
        rd(2'd2, f);
        check(tag, f, exp);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        // Reset state (R10)
        chk_count("R10 reset count", 0);
        chk_flag("R10 reset flag", 0);
        check("R3 reset irq", int'(irq), 0);

        // Rollover on internal ticks (R1, R2)
        tmr_on = 1;
        wr(2'd0, 8'hFD); wr(2'd1, 8'hFF);
        tick_en = 1; cyc(4); tick_en = 0;
        chk_count("R1 count after rollover", 16'h0001);
        chk_flag("R2 flag set by rollover", 1);

        // Sticky flag, clear by write, set beats clear (R2)
        tick_en = 1; cyc(3); tick_en = 0;
        chk_flag("R2 flag sticky", 1);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk_flag("R2 flag cleared by write", 0);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        @(negedge clk);
        tick_en = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        tick_en = 0; wr_en = 0;
        chk_flag("R2 rollover beats clear", 1);
        chk_count("R1 wrap to zero", 0);

        // Enable chain truth table (R3)
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            ie_local = c[0]; ie_periph = c[1]; ie_global = c[2];
            #1;
            check($sformatf("R3 irq combo %0d", c), int'(irq), int'(c == 7));
        end
        ie_local = 0; ie_periph = 0; ie_global = 0;
        wr(2'd2, 8'h00);

        // Trigger clears, no flag (R4)
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        @(negedge clk); trig_pulse = 1;
        @(negedge clk); trig_pulse = 0;
        chk_count("R4 trigger clears", 0);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        @(negedge clk); trig_pulse = 1; tick_en = 1;
        @(negedge clk); trig_pulse = 0; tick_en = 0;
        chk_count("R4 trigger beats increment", 0);
        chk_flag("R4 trigger sets no flag", 0);

        // Write beats trigger (R5)
        wr(2'd1, 8'h12); wr(2'd0, 8'h34);
        @(negedge clk);
        trig_pulse = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 8'h5A;
        @(negedge clk);
        trig_pulse = 0; wr_en = 0;
        chk_count("R5 write wins over trigger", 16'h125A);

        // Trigger ignored in free-running external mode (R4)
        src_ext = 1; ext_async = 1;
        @(negedge clk); trig_pulse = 1;
        @(negedge clk); trig_pulse = 0;
        chk_count("R4 async ignores trigger", 16'h125A);

        // Arming and synchronised latency (R6, R7)
        ext_async = 0;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        @(negedge clk); ext_clk_in = 1;
        cyc(5);
        chk_count("R6 rise before fall ignored", 0);
        ext_clk_in = 0; cyc(4);
        ext_clk_in = 1;
        cyc(2);
        chk_count("R7 sync not yet counted", 0);
        cyc(1);
        chk_count("R7 sync counted after third edge", 1);
        ext_async = 1;
        @(negedge clk); ext_clk_in = 0;
        @(negedge clk); ext_clk_in = 1;
        @(negedge clk);
        chk_count("R7 async counted after one edge", 2);

        // Timer off holds, writes land (R9)
        src_ext = 0; ext_async = 0; tmr_on = 0;
        tick_en = 1; cyc(3); tick_en = 0;
        chk_count("R9 off holds count", 2);
        wr(2'd0, 8'h77);
        @(negedge clk);
        chk_count("R9 write while off", 16'h0077);

        // Low-power behaviour (R8)
        tmr_on = 1;
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        low_power = 1; ie_local = 1; ie_periph = 1; ie_global = 0;
        tick_en = 1; cyc(3); tick_en = 0;
        chk_count("R8 internal ticks held in low power", 16'hFFFF);
        src_ext = 1; ext_async = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); ext_clk_in = ~ext_clk_in;
        end
        cyc(4);
        chk_count("R8 sync external held in low power", 16'hFFFF);
        ext_async = 1;
        @(negedge clk); ext_clk_in = 0;
        @(negedge clk); ext_clk_in = 1;
        @(negedge clk);
        chk_count("R8 async external runs in low power", 0);
        check("R8 wake without global enable", int'(wake), 1);
        check("R3 irq needs global enable", int'(irq), 0);
        ie_global = 1; #1;
        check("R3 irq with full chain", int'(irq), 1);

        // Unused read address (R10)
        rd(2'd3, v);
        check("R10 address 3 reads zero", v, 0);

        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule